// File: doc/BRIEF.md
# Variable-width MSB-first host shift register

This block is the single three-byte shift register that every serial host transfer passes through, in both directions. The interface controller loads it in parallel from the transmit path, then strobes one shift per serial bit. Each shift sends the register's top bit out on the serial output and takes the serial input into the lowest bit of the active window. When the word is complete, the received bits are captured for the receive path. Bus framing, clock generation, queues and addressing belong to other blocks. The register has no host-facing or core-facing access of its own.

A two-bit width select picks 8-, 16- or 24-bit words. The active window is always anchored at the top of the register: an 8-bit word shifts only the top byte, and a 16-bit word shifts the top two bytes. The width is sampled only when a word is loaded, so a change made during a word waits for the next word boundary. A controller with three states sequences the work:
- `ST_IDLE`: after reset. The transition *load* goes to `ST_SHIFT`.
- `ST_SHIFT`: a word is in flight. The transition *last shift* goes to `ST_DONE`.
- `ST_DONE`: the word is complete and the flag is up. The transition *load* goes back to `ST_SHIFT`.

Top module: `hsr_shift_core`

## Requirements
- R1: Width code 2'b00 gives an 8-bit word, 2'b01 a 16-bit word, and 2'b10 or 2'b11 a 24-bit word. `word_done` rises after exactly that many accepted shifts and not before.
- R2: A `load_en` pulse outside a word samples `width_sel` and starts a word. The word is the low N bits of `load_data` (N is the word width); bits above N-1 are ignored. After that clock edge, `ser_out` shows load bit N-1 and `word_done` is 0.
- R3: Bits leave most significant first. Before the k-th accepted shift (k from 0), `ser_out` equals load bit N-1-k.
- R4: Each accepted shift puts `ser_in` at the lowest bit of the active window. At completion, `rx_data` holds the N received bits right-justified, the first bit received at bit N-1, with all bits above N-1 zero.
- R5: Only the top byte (8-bit) or the top two bytes (16-bit) shift. Right after the last shift, `ser_out` equals the first bit received in that word.
- R6: A change of `width_sel` during a word does not change that word's length. It applies at the next load.
- R7: `shift_en` has no effect in `ST_IDLE` or `ST_DONE`: `ser_out`, `rx_data` and `word_done` keep their values.
- R8: `load_en` during a word (`ST_SHIFT`) is ignored. A shift presented in the same cycle still proceeds.
- R9: `rx_data` changes only at the edge that completes a word. It holds through the following word until that word completes.
- R10: After reset, `word_done`, `ser_out` and `rx_data` are 0 and the controller is in `ST_IDLE`.
- R11: A cycle with neither `load_en` nor `shift_en` leaves `ser_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| width_sel | input | 2 | Word width code, sampled at load |
| load_en | input | 1 | Parallel load strobe from the transmit path |
| load_data | input | 24 | Transmit word, right-justified |
| shift_en | input | 1 | One-bit shift strobe |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out (register bit 23) |
| word_done | output | 1 | Word complete flag |
| rx_data | output | 24 | Captured receive word, right-justified, upper bits zero |

## Verification
The assertions assume that `shift_en` and `load_en` are synchronous single-cycle-or-longer levels, and that `width_sel` is stable in the cycle a load is accepted. They also assume that a shift and a load are never both accepted outside a word. In that case the load wins, and the properties are written so that they do not depend on this. The stimulus drives all inputs at the falling edge and keeps them stable through the next rising edge. It mixes random gaps, random widths (including the spare code 2'b11), width changes in mid-word and load strobes in mid-word, so every assumed input pattern is exercised while staying inside these limits.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_DONE  = 2'b10
    } hsr_state_e;

    // number of bytes taking part in a word for a width code
    function automatic int win_bytes(input logic [1:0] code);
        unique case (code)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int win_bits(input logic [1:0] code, input int byte_w);
        return win_bytes(code) * byte_w;
    endfunction

    // lowest register bit of the active window
    function automatic int win_low(input logic [1:0] code, input int byte_w);
        return (3 - win_bytes(code)) * byte_w;
    endfunction

endpackage

// File: rtl/hsr_bit_counter.sv
module hsr_bit_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hsr_ctrl.sv
module hsr_ctrl
    import hsr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic [1:0]       width_sel,
    input  logic [CNT_W-1:0] bit_cnt,
    output hsr_state_e       state_q,
    output logic [1:0]       act_code,
    output logic             load_go,
    output logic             shift_go,
    output logic             last_go,
    output logic             word_done
);

    hsr_state_e state_d;
    logic       at_last;

    assign at_last = (int'(bit_cnt) == win_bits(act_code, BYTE_W) - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            act_code <= 2'b00;
        end else begin
            state_q <= state_d;
            if (load_go) begin
                act_code <= width_sel;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_en)             state_d = ST_SHIFT;
            ST_SHIFT: if (shift_en && at_last) state_d = ST_DONE;
            ST_DONE:  if (load_en)             state_d = ST_SHIFT;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_go   = 1'b0;
        shift_go  = 1'b0;
        last_go   = 1'b0;
        word_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_go = load_en;
            ST_SHIFT: begin
                shift_go = shift_en;
                last_go  = shift_en && at_last;
            end
            ST_DONE: begin
                load_go   = load_en;
                word_done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hsr_window_shifter.sv
module hsr_window_shifter
    import hsr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic              shift_go,
    input  logic              last_go,
    input  logic [1:0]        load_code,
    input  logic [1:0]        act_code,
    input  logic [DATA_W-1:0] load_word,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] sreg_q;
    logic [DATA_W-1:0] shift_nxt;
    int                act_lo;
    int                load_lo;

    assign act_lo  = win_low(act_code, BYTE_W);
    assign load_lo = win_low(load_code, BYTE_W);

    // window bits move up by one, the serial bit enters at the window floor,
    // bits below the window hold
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            if (i > act_lo) begin
                shift_nxt[i] = sreg_q[i-1];
            end else if (i == act_lo) begin
                shift_nxt[i] = ser_in;
            end else begin
                shift_nxt[i] = sreg_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q  <= '0;
            rx_word <= '0;
        end else begin
            if (load_go) begin
                sreg_q <= load_word << load_lo;
            end else if (shift_go) begin
                sreg_q <= shift_nxt;
            end
            if (last_go) begin
                rx_word <= shift_nxt >> act_lo;
            end
        end
    end

    assign ser_out = sreg_q[DATA_W-1];

endmodule

// File: rtl/hsr_shift_core.sv
module hsr_shift_core
    import hsr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 3 * BYTE_W,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        width_sel,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              word_done,
    output logic [DATA_W-1:0] rx_data
);

    hsr_state_e       state_q;
    logic [1:0]       act_code;
    logic [CNT_W-1:0] bit_cnt;
    logic             load_go;
    logic             shift_go;
    logic             last_go;

    hsr_ctrl #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .width_sel (width_sel),
        .bit_cnt   (bit_cnt),
        .state_q   (state_q),
        .act_code  (act_code),
        .load_go   (load_go),
        .shift_go  (shift_go),
        .last_go   (last_go),
        .word_done (word_done)
    );

    hsr_bit_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_go),
        .inc   (shift_go),
        .cnt   (bit_cnt)
    );

    hsr_window_shifter #(
        .BYTE_W (BYTE_W)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_go   (load_go),
        .shift_go  (shift_go),
        .last_go   (last_go),
        .load_code (width_sel),
        .act_code  (act_code),
        .load_word (load_data),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .rx_word   (rx_data)
    );

endmodule

// File: rtl/hsr_shift_core_chk.sv
module hsr_shift_core_chk
    import hsr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 3 * BYTE_W,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              shift_en,
    input logic              ser_out,
    input logic              word_done,
    input logic [DATA_W-1:0] rx_data,
    input hsr_state_e        state_q,
    input logic [1:0]        act_code,
    input logic [CNT_W-1:0]  bit_cnt
);

    // R1
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (int'(bit_cnt) < win_bits(act_code, BYTE_W)));

    // R2
    load_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && state_q != ST_SHIFT) |=> !word_done);

    // R4
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(word_done) && act_code == 2'b00) |-> (rx_data[DATA_W-1:BYTE_W] == '0));

    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !load_en) |=> (word_done && $stable(ser_out) && $stable(rx_data)));

    // R8
    busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && load_en && !shift_en) |=> $stable(ser_out));

    // R9
    rx_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(word_done));

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(ser_out));

endmodule

bind hsr_shift_core hsr_shift_core_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .ser_out   (ser_out),
    .word_done (word_done),
    .rx_data   (rx_data),
    .state_q   (state_q),
    .act_code  (act_code),
    .bit_cnt   (bit_cnt)
);

// File: tb/hsr_shift_core_tb_top.sv
module hsr_shift_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'b00;
    logic        load_en = 1'b0;
    logic [23:0] load_data = '0;
    logic        shift_en = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        word_done;
    logic [23:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [23:0] last_rx = '0;

    always #10ns clk = ~clk;

    hsr_shift_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .width_sel (width_sel),
        .load_en   (load_en),
        .load_data (load_data),
        .shift_en  (shift_en),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .word_done (word_done),
        .rx_data   (rx_data)
    );

    function automatic int nbits(input logic [1:0] c);
        return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 24;
    endfunction

    function automatic logic [23:0] wmask(input logic [1:0] c);
        return 24'hFFFFFF >> (24 - nbits(c));
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_word(input logic [1:0] code, input logic [23:0] raw, input logic [23:0] rxw,
                            input bit chg, input bit inj, input bit gaps);
        int n = nbits(code);
        logic [23:0] txm = raw & wmask(code);
        logic [23:0] rxm = rxw & wmask(code);
        bit sent_ok = 1;
        bit early = 0;
        width_sel = code; load_data = raw; load_en = 1'b1; shift_en = 1'b0;
        tick();
        load_en = 1'b0;
        check(word_done == 1'b0, "R2 done cleared by load", {23'd0, word_done}, 24'd0);
        check(ser_out == txm[n-1], "R2 first bit after load", {23'd0, ser_out}, {23'd0, txm[n-1]});
        for (int k = 0; k < n; k++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                logic held = ser_out;
                shift_en = 1'b0; load_en = 1'b0;
                tick();
                check(ser_out == held, "R11 quiet cycle holds", {23'd0, ser_out}, {23'd0, held});
            end
            load_en = 1'b0;
            if (chg && k == n / 2) width_sel = (code == 2'b00) ? 2'b10 : 2'b00;
            if (k == n / 2) check(rx_data == last_rx, "R9 rx held mid-word", rx_data, last_rx);
            if (ser_out !== txm[n-1-k]) sent_ok = 0;
            if (word_done) early = 1;
            if (inj && k == 1) begin
                load_en = 1'b1; load_data = ~raw;
            end
            ser_in = rxw[n-1-k]; shift_en = 1'b1;
            tick();
        end
        shift_en = 1'b0; load_en = 1'b0;
        check(sent_ok, "R3 MSB-first stream", txm, txm);
        check(!early && word_done, chg ? "R6 length kept after width change" : "R1 done after N shifts",
              {23'd0, word_done}, 24'd1);
        if (inj) check(sent_ok && word_done, "R8 mid-word load ignored", {23'd0, word_done}, 24'd1);
        check(rx_data == rxm, "R4 received word right-justified", rx_data, rxm);
        check(ser_out == rxm[n-1], "R5 window wraps at top", {23'd0, ser_out}, {23'd0, rxm[n-1]});
        last_rx = rxm;
    endtask

    task automatic poke_shifts(input string req);
        logic so = ser_out;
        logic wd = word_done;
        logic [23:0] rr = rx_data;
        for (int i = 0; i < 3; i++) begin
            ser_in = ~ser_in; shift_en = 1'b1;
            tick();
        end
        shift_en = 1'b0;
        check(ser_out == so && word_done == wd && rx_data == rr, req, {ser_out, word_done, rx_data[21:0]},
              {so, wd, rr[21:0]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R10 reset values
        check(word_done == 1'b0 && ser_out == 1'b0 && rx_data == 24'd0, "R10 reset state",
              {ser_out, word_done, rx_data[21:0]}, 24'd0);
        rst_n = 1'b1;
        tick();
        poke_shifts("R7 shift ignored in idle");
        // directed widths
        run_word(2'b00, 24'h1234A5, 24'h00003C, 0, 0, 0);
        poke_shifts("R7 shift ignored when done");
        run_word(2'b01, 24'hFFC3E1, 24'h00B00D, 0, 0, 0);
        run_word(2'b10, 24'h800001, 24'hA5F00F, 0, 0, 0);
        run_word(2'b11, 24'h7FFFFE, 24'h5A5A5A, 0, 0, 0);
        // R6 width change mid-word, both directions
        run_word(2'b00, 24'h0000FF, 24'h000081, 1, 0, 0);
        run_word(2'b10, 24'hC0FFEE, 24'h123456, 1, 0, 0);
        // R8 load during a word
        run_word(2'b01, 24'h00ACE1, 24'h00BEEF, 0, 1, 0);
        // random mix
        for (int w = 0; w < 60; w++) begin
            run_word(2'($urandom % 4), 24'($urandom), 24'($urandom),
                     ($urandom % 5) == 0, ($urandom % 6) == 0, 1);
            if ($urandom % 4 == 0) poke_shifts("R7 shift ignored when done");
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule